// File: doc/BRIEF.md
# Four-Channel Converter Sequencer Controller

This block is the digital control core of a four-channel sampling converter that is driven over a 16-clock serial port. An active-low chip select frames each transfer. While the host shifts a control word in on the data input, the block shifts out the result of the previous conversion. Each completed transfer triggers exactly one conversion. The analog front end is modelled by a parallel 12-bit sample input, which must present the value of the channel shown on the channel-select output.

The control register holds a two-bit sequencer code and a two-bit channel address. Codes 0,0 and 0,1 convert the addressed channel on every transfer. Code 1,1 starts a sweep that runs from channel 0 upward to the addressed channel and then wraps back to 0 for as long as it is left alone. A transfer that clears the write bit leaves the register as it was, and so does a write that carries code 1,0. A sweep therefore keeps running while the host reads results.

All serial inputs are sampled on the system clock. The serial clock must be slower than the system clock, with at least two system-clock cycles per phase. The data output changes after a falling serial-clock edge, and the data input is taken on a rising edge.

Top module: `adc_seq_top`

## Requirements
- R1: After reset the block is in single-channel mode on channel 0, the channel-select output is 0, and the first frame shifted out is all zeros.
- R2: Each output frame is 16 bits, MSB first: bits 15:14 are zero, bits 13:12 are the channel that was converted, and bits 11:0 are its sample. The frame holds the conversion done by the most recent completed transfer before it, and the data output does not change on a rising serial-clock edge.
- R3: With sequencer code 0,0 or 0,1 written, every later transfer converts the addressed channel.
- R4: A write with sequencer code 1,1 makes the next transfer convert channel 0, and each transfer after that converts the next higher channel.
- R5: After the transfer that converts the final (addressed) channel of a sweep, the next transfer converts channel 0 again, with no register write needed.
- R6: A completed transfer whose write bit is 0 leaves the register unchanged, whatever the other bits hold (an all-zero word included), and a running sweep keeps advancing.
- R7: A write carrying sequencer code 1,0 changes neither the register nor the sweep's final channel, and the sweep keeps advancing.
- R8: A write with sequencer code 0,0 or 0,1 ends a running sweep, and the next transfer converts the newly addressed channel.
- R9: A transfer with fewer than 16 rising serial-clock edges before chip select rises performs no conversion and leaves the register and the channel selection unchanged.
- R10: The control word is taken MSB first. Bit 15 is the write bit, bit 14 is reserved and ignored, bits 13:12 are the sequencer code, bits 11:10 are the channel address, and bits 9:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low transfer frame |
| sclk | input | 1 | Serial clock, sampled on clk |
| din | input | 1 | Serial control word, MSB first |
| dout | output | 1 | Serial result frame, MSB first |
| sample_in | input | 12 | Conversion value for the channel on ch_sel |
| ch_sel | output | 2 | Channel to be converted by the next completed transfer |

## Verification
The bench drives a series of transfers of the following kinds:
- single-channel writes on different addresses, which show whether the address field is honoured;
- read-only transfers, with the word all zero and also with a nonzero word carrying a cleared write bit, which separate ignoring the word from decoding it;
- a sweep that runs through its wrap from the final channel back to 0, which checks that the channel tag in each frame matches the sample;
- a code 1,0 write in the middle of a sweep and an aborted nine-clock transfer, which must both leave the sweep untouched;
- a terminating single-channel write;
- a sweep started with the reserved bit set.

Each sample is derived from the channel number and the transfer index, so a wrong channel, a stale result or an off-by-one frame each gives a different mismatch.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int CH_W    = 2;
    localparam int SMP_W   = 12;
    localparam int FRAME_W = 2 + CH_W + SMP_W;
    localparam int CNT_W   = $clog2(FRAME_W) + 1;

    // control word field positions (MSB first)
    localparam int WR_BIT  = FRAME_W - 1;
    localparam int SEQ_HI  = FRAME_W - 3;
    localparam int ADDR_HI = FRAME_W - 5;

    typedef enum logic [1:0] {
        SEQ_ONE_A = 2'b00,
        SEQ_ONE_B = 2'b01,
        SEQ_HOLD  = 2'b10,
        SEQ_SWEEP = 2'b11
    } seq_code_e;

    typedef struct packed {
        logic            wr;
        seq_code_e       seq;
        logic [CH_W-1:0] addr;
    } ctrl_word_t;

    function automatic logic [FRAME_W-1:0] build_frame(
        input logic [CH_W-1:0]  ch,
        input logic [SMP_W-1:0] smp
    );
        return {2'b00, ch, smp};
    endfunction

    function automatic logic [CH_W-1:0] next_sweep_ch(
        input logic [CH_W-1:0] cur,
        input logic [CH_W-1:0] last
    );
        return (cur == last) ? '0 : cur + 1'b1;
    endfunction

endpackage

// File: rtl/adc_seq_serial.sv
module adc_seq_serial
    import adc_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cs_n,
    input  logic               sclk,
    input  logic               din,
    input  logic [FRAME_W-1:0] tx_frame,
    output logic               dout,
    output logic               frame_done,
    output ctrl_word_t         rx_ctrl
);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

    logic               sclk_d, cs_d;
    logic [CNT_W-1:0]   bit_cnt;
    logic [FRAME_W-1:0] tx_sr, rx_sr;
    logic               sclk_rise, sclk_fall, cs_fall, cs_rise;

    assign sclk_rise = sclk && !sclk_d;
    assign sclk_fall = !sclk && sclk_d;
    assign cs_fall   = !cs_n && cs_d;
    assign cs_rise   = cs_n && !cs_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d     <= 1'b0;
            cs_d       <= 1'b1;
            bit_cnt    <= '0;
            tx_sr      <= '0;
            rx_sr      <= '0;
            frame_done <= 1'b0;
        end else begin
            sclk_d     <= sclk;
            cs_d       <= cs_n;
            frame_done <= cs_rise && (bit_cnt == CNT_FULL);
            if (cs_fall) begin
                tx_sr   <= tx_frame;
                bit_cnt <= '0;
            end else if (!cs_n) begin
                if (sclk_rise) begin
                    rx_sr <= {rx_sr[FRAME_W-2:0], din};
                    if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
                end
                if (sclk_fall) tx_sr <= {tx_sr[FRAME_W-2:0], 1'b0};
            end
        end
    end

    assign dout    = tx_sr[FRAME_W-1];
    assign rx_ctrl = '{wr:   rx_sr[WR_BIT],
                       seq:  seq_code_e'(rx_sr[SEQ_HI -: 2]),
                       addr: rx_sr[ADDR_HI -: CH_W]};

    // R2
    dout_hold_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (sclk_rise && !cs_n && !cs_fall) |=> $stable(dout));

    // R9
    short_frame_chk: assert property (@(posedge clk) disable iff (rst)
        (cs_rise && bit_cnt != CNT_FULL) |=> !frame_done);

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            frame_done,
    input  ctrl_word_t      rx_ctrl,
    output logic [CH_W-1:0] ch_sel
);
    seq_code_e       reg_seq;
    logic [CH_W-1:0] reg_addr;
    logic [CH_W-1:0] sweep_ch;
    logic            sweeping, take_word;

    assign sweeping  = (reg_seq == SEQ_SWEEP);
    assign take_word = rx_ctrl.wr && (rx_ctrl.seq != SEQ_HOLD);

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_seq  <= SEQ_ONE_A;
            reg_addr <= '0;
            sweep_ch <= '0;
        end else if (frame_done) begin
            if (take_word) begin
                reg_seq  <= rx_ctrl.seq;
                reg_addr <= rx_ctrl.addr;
                sweep_ch <= '0;
            end else if (sweeping) begin
                sweep_ch <= next_sweep_ch(sweep_ch, reg_addr);
            end
        end
    end

    assign ch_sel = sweeping ? sweep_ch : reg_addr;

    // R6
    readonly_keeps_reg_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_done && !rx_ctrl.wr) |=> ($stable(reg_seq) && $stable(reg_addr)));

    // R4
    sweep_starts_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_done && rx_ctrl.wr && rx_ctrl.seq == SEQ_SWEEP) |=> (ch_sel == '0));

    // R5
    sweep_wraps_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_done && sweeping && !take_word && ch_sel == reg_addr) |=> (ch_sel == '0));

    // R8
    sweep_ends_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_done && rx_ctrl.wr && !rx_ctrl.seq[1])
        |=> (!sweeping && ch_sel == $past(rx_ctrl.addr)));

    // R7
    hold_code_keeps_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_done && rx_ctrl.wr && rx_ctrl.seq == SEQ_HOLD) |=> $stable(reg_addr));

endmodule

// File: rtl/adc_seq_result.sv
module adc_seq_result
    import adc_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               frame_done,
    input  logic [CH_W-1:0]    ch_sel,
    input  logic [SMP_W-1:0]   sample_in,
    output logic [FRAME_W-1:0] tx_frame
);
    logic [CH_W-1:0]  res_ch;
    logic [SMP_W-1:0] res_smp;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_ch  <= '0;
            res_smp <= '0;
        end else if (frame_done) begin
            res_ch  <= ch_sel;
            res_smp <= sample_in;
        end
    end

    assign tx_frame = build_frame(res_ch, res_smp);

    // R2
    result_held_chk: assert property (@(posedge clk) disable iff (rst)
        !frame_done |=> $stable(tx_frame));

endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
    import adc_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             sclk,
    input  logic             din,
    output logic             dout,
    input  logic [SMP_W-1:0] sample_in,
    output logic [CH_W-1:0]  ch_sel
);
    logic               frame_done;
    ctrl_word_t         rx_ctrl;
    logic [FRAME_W-1:0] tx_frame;

    adc_seq_serial u_serial (
        .clk        (clk),
        .rst        (rst),
        .cs_n       (cs_n),
        .sclk       (sclk),
        .din        (din),
        .tx_frame   (tx_frame),
        .dout       (dout),
        .frame_done (frame_done),
        .rx_ctrl    (rx_ctrl)
    );

    adc_seq_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .frame_done (frame_done),
        .rx_ctrl    (rx_ctrl),
        .ch_sel     (ch_sel)
    );

    adc_seq_result u_result (
        .clk        (clk),
        .rst        (rst),
        .frame_done (frame_done),
        .ch_sel     (ch_sel),
        .sample_in  (sample_in),
        .tx_frame   (tx_frame)
    );

    // R1
    reset_state_chk: assert property (@(posedge clk)
        $past(rst) |-> (ch_sel == '0 && tx_frame == '0));

endmodule

// File: tb/adc_seq_top_bench.sv
module adc_seq_top_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        cs_n, sclk, din;
    logic        dout;
    logic [11:0] sample_in;
    logic [1:0]  ch_sel;
    logic [11:0] base;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    typedef struct {
        logic [15:0] val;
        string       tag;
    } exp_t;

    exp_t        sb_q[$];
    logic [15:0] got_frame;
    event        frame_ev;

    // bench model state, built from the requirements
    logic [1:0]  m_seq, m_addr, m_ch;
    logic [1:0]  r_ch;
    logic [11:0] r_smp;

    always #10 clk = ~clk;

    adc_seq_top u_adc_seq_top (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .din(din),
        .dout(dout), .sample_in(sample_in), .ch_sel(ch_sel)
    );

    function automatic logic [11:0] smp_of(input logic [1:0] ch, input logic [11:0] b);
        return ({10'd0, ch} * 12'h151) ^ b;
    endfunction

    assign sample_in = smp_of(ch_sel, base);

    function automatic logic [15:0] mk(input logic wr, input logic rsv,
                                       input logic [1:0] seq, input logic [1:0] addr,
                                       input logic [9:0] junk);
        return {wr, rsv, seq, addr, junk};
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic model_apply(input logic [15:0] w);
        if (w[15] && w[13:12] != 2'b10) begin
            m_seq  = w[13:12];
            m_addr = w[11:10];
            m_ch   = (w[13:12] == 2'b11) ? 2'b00 : w[11:10];
        end else if (m_seq == 2'b11) begin
            m_ch = (m_ch == m_addr) ? 2'b00 : m_ch + 2'd1;
        end
    endtask

    // driver: pushes the expected frame, runs the transfer, updates the model
    task automatic xfer(input logic [15:0] w, input int nbits, input string tag);
        exp_t        e;
        logic [15:0] got = '0;
        base = base + 12'h2B7;
        check(ch_sel == m_ch, tag, "ch_sel before transfer", ch_sel, m_ch);
        if (nbits == 16) begin
            e.val = {2'b00, r_ch, r_smp};
            e.tag = tag;
            sb_q.push_back(e);
        end
        cs_n = 1'b0;
        tick(3);
        for (int i = 0; i < nbits; i++) begin
            got[15-i] = dout;
            din  = w[15-i];
            sclk = 1'b1;
            tick(2);
            sclk = 1'b0;
            tick(2);
        end
        din  = 1'b0;
        cs_n = 1'b1;
        tick(4);
        if (nbits == 16) begin
            got_frame = got;
            ->frame_ev;
            r_ch  = m_ch;
            r_smp = smp_of(m_ch, base);
            model_apply(w);
        end
        tick(1);
    endtask

    // monitor: compares each completed frame with the oldest expected item
    initial begin
        exp_t e;
        forever begin
            @(frame_ev);
            if (sb_q.size() == 0) begin
                check(1'b0, "R2", "unexpected frame", got_frame, 0);
            end else begin
                e = sb_q.pop_front();
                check(got_frame == e.val, e.tag, "frame", got_frame, e.val);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cs_n = 1'b1; sclk = 1'b0; din = 1'b0; base = 12'h0;
        m_seq = 2'b00; m_addr = 2'b00; m_ch = 2'b00; r_ch = 2'b00; r_smp = 12'h0;
        tick(3);
        rst = 1'b0;
        tick(2);
        check(ch_sel == 2'b00, "R1", "ch_sel after reset", ch_sel, 0);

        // R1: first frame all zeros; R3 write single channel 2
        xfer(mk(1, 0, 2'b00, 2'd2, 10'h000), 16, "R1");
        // R6: all-zero word; R3: channel 2 kept
        xfer(16'h0000, 16, "R3");
        // R6: write bit clear with other bits set
        xfer(mk(0, 1, 2'b11, 2'd3, 10'h3FF), 16, "R6");
        // R3: single mode, code 0,1 on channel 1
        xfer(mk(1, 0, 2'b01, 2'd1, 10'h155), 16, "R3");
        xfer(16'h0000, 16, "R3");
        // R4: sweep 0..2
        xfer(mk(1, 0, 2'b11, 2'd2, 10'h000), 16, "R4");
        for (int k = 0; k < 7; k++) xfer(16'h0000, 16, "R5");
        // R7: hold code in mid-sweep with a different address
        xfer(mk(1, 0, 2'b10, 2'd3, 10'h0AA), 16, "R7");
        xfer(16'h0000, 16, "R7");
        // R9: aborted transfer carrying a terminating write
        xfer(mk(1, 0, 2'b00, 2'd3, 10'h000), 9, "R9");
        xfer(16'h0000, 16, "R9");
        xfer(16'h0000, 16, "R5");
        // R8: terminating single write to channel 3
        xfer(mk(1, 0, 2'b00, 2'd3, 10'h000), 16, "R8");
        xfer(16'h0000, 16, "R8");
        xfer(16'h0000, 16, "R8");
        // R10: reserved and low bits set, sweep to channel 1
        xfer(mk(1, 1, 2'b11, 2'd1, 10'h3C3), 16, "R10");
        for (int k = 0; k < 4; k++) xfer(16'h0000, 16, "R10");
        // R2: flush last result
        xfer(16'h0000, 16, "R2");

        tick(4);
        check(sb_q.size() == 0, "R2", "pending frames", sb_q.size(), 0);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule